// File: doc/BRIEF.md
# Five-Source Interrupt Controller

This block collects interrupt requests from five sources (vertical blank, LCD status, timer, serial link and joypad). Each source sends a one-cycle pulse that latches a bit in a flag register. A second register holds one enable bit per source. A master enable, set and cleared by the CPU through two strobes, gates whether anything is reported as pending.

When at least one source has its flag and its enable set and the master enable is high, the block raises a pending line. It also presents the vector address of the winning source. When the CPU acknowledges, the winner's flag bit and the master enable are cleared in the same edge. Both registers sit on a byte-wide register bus with a combinational read port.

Top module: `irq_hub`

## Requirements
- R1: After reset, both registers read back as 0xE0, and nothing is pending.
- R2: A write to address 0xFFFF stores the low five bits as the enable mask. A read of 0xFFFF returns that mask ORed with 0xE0.
- R3: A write to address 0xFF0F stores the low five bits as the flag bits. A read of 0xFF0F returns them ORed with 0xE0.
- R4: A pulse on `src_req[k]` sets flag bit k on the next edge and leaves the other flag bits unchanged. The sources are mapped to bits as follows: bit 0 is vertical blank, bit 1 is LCD status, bit 2 is timer, bit 3 is serial and bit 4 is joypad.
- R5: `irq_pending` is high only when some source has its flag bit set, its enable bit set and the master enable high.
- R6: When several sources are pending, the lowest bit number wins. `irq_vector` is then 0x40 + 8×bit (0x40, 0x48, 0x50, 0x58, 0x60). It is 0 when nothing is pending.
- R7: On `ack`, the flag bit of the current winner is cleared, the other flag bits are kept, and the master enable is cleared.
- R8: If a request pulse and a flag-register write arrive in the same cycle, the request bit is set on top of the written value.
- R9: `ime_set` raises the master enable. `ime_clr` lowers it, and `ime_clr` wins when both are asserted in the same cycle.
- R10: Writes to any other address change neither register, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register bus address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| src_req | input | 5 | One-cycle request pulses, one per source |
| ime_set | input | 1 | Raise the master enable |
| ime_clr | input | 1 | Lower the master enable |
| ack | input | 1 | CPU acknowledge of the current winner |
| irq_pending | output | 1 | An enabled source is flagged and the master enable is high |
| irq_vector | output | 16 | Vector address of the winning source |

## Verification
The bench builds the block with its default parameters: five sources, vector base 0x40, a vector step of 8, and register addresses 0xFFFF and 0xFF0F. With these values every flag and enable combination can be reached, and so can every vector from 0x40 to 0x60. Directed sequences then cover the same-cycle corners: a write colliding with a request, and set colliding with clear. A long run of random requests, writes and acknowledges is compared against a behavioural model on every clock.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC = 5,
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int VW = 16,
  parameter logic [AW-1:0] EN_ADDR = 16'hFFFF,
  parameter logic [AW-1:0] FLAG_ADDR = 16'hFF0F,
  parameter logic [VW-1:0] VEC_BASE = 16'h0040,
  parameter int VEC_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NSRC-1:0] src_req,
  input  logic          ime_set,
  input  logic          ime_clr,
  input  logic          ack,
  output logic          irq_pending,
  output logic [VW-1:0] irq_vector
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [DW-1:0] FILL = {DW{1'b1}} << NSRC;

  logic [NSRC-1:0] en_q, flag_q, live, win_mask, flag_d;
  logic [IW-1:0] win_idx;
  logic ime_q;

  assign live = en_q & flag_q & {NSRC{ime_q}};
  assign irq_pending = |live;

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (live[i]) win_idx = IW'(i);
  end

  assign win_mask = irq_pending ? (NSRC'(1) << win_idx) : '0;
  assign irq_vector = irq_pending ? VEC_BASE + VW'(win_idx) * VW'(VEC_STEP) : '0;

  always_comb begin
    if (reg_addr == EN_ADDR)
      reg_rdata = FILL | DW'(en_q);
    else if (reg_addr == FLAG_ADDR)
      reg_rdata = FILL | DW'(flag_q);
    else
      reg_rdata = '0;
  end

  always_comb begin
    flag_d = (reg_we && reg_addr == FLAG_ADDR) ? reg_wdata[NSRC-1:0] : flag_q;
    if (ack) flag_d = flag_d & ~win_mask;
    flag_d = flag_d | src_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      flag_q <= '0;
      ime_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (reg_we && reg_addr == EN_ADDR) en_q <= reg_wdata[NSRC-1:0];
      if (ime_clr || ack) ime_q <= 1'b0;
      else if (ime_set) ime_q <= 1'b1;
    end
  end
endmodule

module irq_hub_chk #(
  parameter int NSRC = 5,
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_BASE = 16'h0040
) (
  input logic clk,
  input logic rst_n,
  input logic [NSRC-1:0] src_req,
  input logic ack,
  input logic ime_clr,
  input logic ime_q,
  input logic [NSRC-1:0] flag_q,
  input logic irq_pending,
  input logic [VW-1:0] irq_vector
);
  // R4
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req != '0) |=> ((flag_q & $past(src_req)) == $past(src_req)));
  // R7
  ack_drops_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ime_q);
  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ime_clr |=> !ime_q);
  // R5
  pending_needs_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (ime_q && flag_q != '0));
  // R6
  vector_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (irq_vector[2:0] == 3'b000 && irq_vector >= VEC_BASE));
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .ack(ack), .ime_clr(ime_clr),
  .ime_q(ime_q), .flag_q(flag_q), .irq_pending(irq_pending), .irq_vector(irq_vector)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] reg_addr = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [4:0] src_req = 0;
  logic ime_set = 0, ime_clr = 0, ack = 0;
  logic irq_pending;
  logic [15:0] irq_vector;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_ie = 0, m_if = 0, m_ime = 0;

  always #5 clk = ~clk;

  irq_hub uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
    .ime_set(ime_set), .ime_clr(ime_clr), .ack(ack),
    .irq_pending(irq_pending), .irq_vector(irq_vector));

  function automatic int m_win();
    for (int b = 0; b < 5; b++)
      if (m_ime != 0 && ((m_ie >> b) & (m_if >> b) & 1) != 0) return b;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int w = m_win();
    int rd = (reg_addr == 16'hFFFF) ? (m_ie | 'hE0) :
             (reg_addr == 16'hFF0F) ? (m_if | 'hE0) : 0;
    chk(tag, irq_pending, w >= 0);
    chk(tag, irq_vector, w >= 0 ? 'h40 + 8 * w : 0);
    chk(tag, reg_rdata, rd);
  endtask

  // drive inputs, advance one edge with the model, compare at the falling edge
  task automatic cyc(string tag, logic [15:0] a, logic we, logic [7:0] wd,
                     logic [4:0] rq, logic st, logic cl, logic ak);
    int w, nf;
    reg_addr = a; reg_we = we; reg_wdata = wd; src_req = rq;
    ime_set = st; ime_clr = cl; ack = ak;
    w = m_win();
    nf = (we && a == 16'hFF0F) ? (wd & 'h1F) : m_if;
    if (ak && w >= 0) nf = nf & ~(1 << w);
    nf = nf | rq;
    @(posedge clk);
    if (rst_n) begin
      m_if = nf;
      if (we && a == 16'hFFFF) m_ie = wd & 'h1F;
      if (cl || ak) m_ime = 0; else if (st) m_ime = 1;
    end
    @(negedge clk);
    reg_we = 0; src_req = 0; ime_set = 0; ime_clr = 0; ack = 0;
    compare(tag);
  endtask

  task automatic rd(string tag, logic [15:0] a, int exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd("R1", 16'hFFFF, 'hE0);
    rd("R1", 16'hFF0F, 'hE0);
    chk("R1", irq_pending, 0);

    cyc("R2", 16'hFFFF, 1, 8'h1F, 0, 0, 0, 0);
    rd("R2", 16'hFFFF, 'hFF);
    cyc("R2", 16'hFFFF, 1, 8'hA5, 0, 0, 0, 0);
    rd("R2", 16'hFFFF, 'hE5);

    cyc("R3", 16'hFF0F, 1, 8'h0A, 0, 0, 0, 0);
    rd("R3", 16'hFF0F, 'hEA);

    cyc("R4", 16'hFF0F, 0, 0, 5'b00100, 0, 0, 0);
    rd("R4", 16'hFF0F, 'hEE);
    cyc("R4", 16'hFF0F, 0, 0, 5'b10000, 0, 0, 0);
    rd("R4", 16'hFF0F, 'hFE);

    cyc("R5", 16'hFFFF, 1, 8'h04, 0, 0, 0, 0);
    chk("R5", irq_pending, 0);
    cyc("R5", 16'hFFFF, 0, 0, 0, 1, 0, 0);
    chk("R5", irq_pending, 1);
    chk("R6", irq_vector, 'h50);
    cyc("R5", 16'hFFFF, 1, 8'h00, 0, 0, 0, 0);
    chk("R5", irq_pending, 0);

    cyc("R6", 16'hFFFF, 1, 8'h1F, 0, 0, 0, 0);
    cyc("R6", 16'hFF0F, 1, 8'h18, 0, 0, 0, 0);
    chk("R6", irq_vector, 'h58);
    cyc("R7", 16'hFF0F, 0, 0, 0, 0, 0, 1);
    rd("R7", 16'hFF0F, 'hF0);
    chk("R7", irq_pending, 0);
    cyc("R6", 16'hFF0F, 0, 0, 0, 1, 0, 0);
    chk("R6", irq_vector, 'h60);
    cyc("R6", 16'hFF0F, 1, 8'h1F, 0, 0, 0, 0);
    chk("R6", irq_vector, 'h40);
    cyc("R6", 16'hFF0F, 1, 8'h02, 0, 0, 0, 0);
    chk("R6", irq_vector, 'h48);

    cyc("R8", 16'hFF0F, 1, 8'h00, 5'b00010, 0, 0, 0);
    rd("R8", 16'hFF0F, 'hE2);
    cyc("R8", 16'hFF0F, 1, 8'h08, 5'b00001, 0, 0, 0);
    rd("R8", 16'hFF0F, 'hE9);

    cyc("R9", 16'hFF0F, 0, 0, 0, 1, 1, 0);
    chk("R9", irq_pending, 0);
    cyc("R9", 16'hFF0F, 0, 0, 0, 1, 0, 0);
    chk("R9", irq_pending, 1);

    cyc("R10", 16'h1234, 1, 8'hFF, 0, 0, 0, 0);
    rd("R10", 16'h1234, 0);
    rd("R10", 16'hFF0F, 'hE9);
    rd("R10", 16'hFFFF, 'hFF);

    for (int n = 0; n < 600; n++) begin
      int r = $urandom;
      logic [15:0] a = (r[1:0] == 0) ? 16'hFFFF : (r[1:0] == 1) ? 16'hFF0F :
                       (r[1:0] == 2) ? 16'hFF0E : 16'hFF0F;
      cyc("R6", a, r[2], 8'(r >> 8), 5'(r >> 16) & {5{r[3] & r[4]}},
          r[21] & r[22], r[23] & r[24] & r[25], r[26] & r[27]);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule